// File: doc/BRIEF.md
# Bus Bridge Address Window Translator

This block sits between a processor-side request port and a downstream bus with four address spaces: memory (index 0), I/O (index 1), configuration (index 2) and special (index 3). Each space owns at most one translation window, given by an upstream base, a downstream base and a byte size. An upstream read or write is forwarded to a space only when the whole access, from its start address through start plus byte count, lies inside that space's window. The forwarded address keeps its offset from the upstream base and is moved onto the downstream base.

Requests that start on the downstream side (DMA) are filtered on their way up. Only the memory space may carry DMA. A DMA request that touches the bridge's own downstream memory window is refused. Any other DMA request is passed upward unchanged, to the parent space recorded with the memory window.

A configuration command port loads windows, clears all of them, and checks that at least one window is in use. Configuration faults are held in sticky status bits, and a write-one-to-clear mask clears them.

Top module: `bridge_window_xlate`

## Requirements
- R1: After reset, all window sizes are zero (all windows unused), `errStatus` is 0, and no response or forward valid is asserted.
- R2: A load command (`cfgOp`=0) with `cfgSpaceIdx` 0..3 into a window whose size is zero stores the upstream base, downstream base, size and parent space. A later access can use the window from the next cycle.
- R3: A load into a window whose size is nonzero sets `errStatus` bit 1 (duplicate) and leaves the stored window unchanged.
- R4: A load with `cfgSpaceIdx` 4..7 sets `errStatus` bit 0 (invalid space) and changes no window.
- R5: An upstream access matches a window when the size is nonzero, addr >= upstream base, and addr+len <= upstream base+size, evaluated without wrap. On a match, the bridge forwards `dnAddr` = addr - upstream base + downstream base, with `dnSpace` = window index, the same length and the same write flag. The response length is `len` and `upRspErr` is 0.
- R6: An upstream access that matches no window responds with length 0 and `upRspErr`=1, and `dnValid` stays low.
- R7: When several windows match, the lowest space index wins.
- R8: A DMA request whose `dmaSpace` is not 0 (memory) responds with `dmaRspErr`=1 and length 0, and nothing is forwarded upward.
- R9: When the memory window is in use, a DMA request is refused in the same way as R8 if its start or its end (addr+len) lies in the closed range [downstream base, downstream base+size].
- R10: Any other memory DMA request is forwarded upward with its address, length and write flag unchanged. `fwdSpace` equals the memory window's parent space, and the response length is `len` with `dmaRspErr`=0.
- R11: An init command (`cfgOp`=1) clears every window size. A check command (`cfgOp`=2) when no window is in use sets `errStatus` bit 2.
- R12: Status bits are sticky. With `clrValid`, each bit set in `clrMask` is cleared. A fault raised in the same cycle as its clear wins, so the bit stays set.
- R13: Both request ports are ready outside reset. Each accepted request yields exactly one response valid, in the cycle after acceptance, together with any forward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgValid | input | 1 | Configuration command strobe |
| cfgOp | input | 2 | 0 load, 1 init, 2 check, 3 no effect |
| cfgSpaceIdx | input | 3 | Target space of a load |
| cfgParentBase | input | ADDR_W | Upstream window base |
| cfgChildBase | input | ADDR_W | Downstream window base |
| cfgSize | input | ADDR_W | Window size in bytes, 0 means unused |
| cfgParentSpace | input | 2 | Upstream space used for DMA |
| clrValid | input | 1 | Status clear strobe |
| clrMask | input | 3 | Write-one-to-clear mask |
| errStatus | output | 3 | bit0 invalid space, bit1 duplicate, bit2 no window |
| upValid | input | 1 | Upstream request valid |
| upReady | output | 1 | Upstream request ready |
| upWrite | input | 1 | Upstream write flag |
| upAddr | input | ADDR_W | Upstream address |
| upLen | input | LEN_W | Upstream byte count |
| upRspValid | output | 1 | Upstream response valid |
| upRspLen | output | LEN_W | Bytes transferred |
| upRspErr | output | 1 | No window matched |
| dnValid | output | 1 | Downstream forward valid |
| dnSpace | output | 2 | Downstream space index |
| dnAddr | output | ADDR_W | Rebased address |
| dnLen | output | LEN_W | Forwarded byte count |
| dnWrite | output | 1 | Forwarded write flag |
| dmaValid | input | 1 | DMA request valid |
| dmaReady | output | 1 | DMA request ready |
| dmaWrite | input | 1 | DMA write flag |
| dmaSpace | input | 2 | DMA target space |
| dmaAddr | input | ADDR_W | DMA address |
| dmaLen | input | LEN_W | DMA byte count |
| dmaRspValid | output | 1 | DMA response valid |
| dmaRspLen | output | LEN_W | Bytes passed upward |
| dmaRspErr | output | 1 | DMA refused |
| fwdValid | output | 1 | Upward forward valid |
| fwdSpace | output | 2 | Upstream space |
| fwdAddr | output | ADDR_W | Upward address |
| fwdLen | output | LEN_W | Upward byte count |
| fwdWrite | output | 1 | Upward write flag |

## Verification
Upstream accesses are placed well inside a window, ending exactly on its last byte, crossing its end by a few bytes, and just below its base. These cases separate a start-only match from a full-fit match, and an inclusive end from an exclusive one. A special window that overlaps the memory window shows whether the lowest index wins. DMA addresses that start at, end at, and sit one byte beyond each edge of the downstream memory window test the closed bounds of the refusal range, and a DMA request to a non-memory space tests the space filter. Load, duplicate, invalid-index, init and check commands, with clears that collide with fresh faults, each produce a distinct status pattern.

// File: rtl/bwx_pkg.sv
package bwx_pkg;
  localparam int NUM_SPACES = 4;
  localparam int SPACE_W    = $clog2(NUM_SPACES);
  localparam int IDX_W      = SPACE_W + 1;
  localparam int ERR_W      = 3;
  localparam int ERR_BADSPACE = 0;
  localparam int ERR_DUP      = 1;
  localparam int ERR_NOWIN    = 2;

  typedef enum logic [SPACE_W-1:0] {
    SP_MEM = 2'd0,
    SP_IO  = 2'd1,
    SP_CFG = 2'd2,
    SP_SPC = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_INIT  = 2'd1,
    OP_CHECK = 2'd2,
    OP_NONE  = 2'd3
  } cfg_op_e;

  typedef struct packed {
    logic loadWin;
    logic initAll;
    logic upAccept;
    logic dmaAccept;
  } strobe_t;
endpackage

// File: rtl/bwx_ctrl.sv
module bwx_ctrl
  import bwx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfgValid,
  input  logic [1:0]            cfgOp,
  input  logic [IDX_W-1:0]      cfgSpaceIdx,
  input  logic [NUM_SPACES-1:0] occupied,
  input  logic                  clrValid,
  input  logic [ERR_W-1:0]      clrMask,
  input  logic                  upValid,
  input  logic                  dmaValid,
  output strobe_t               strb,
  output logic [ERR_W-1:0]      errStatus,
  output logic                  upReady,
  output logic                  dmaReady,
  output logic                  upRspValid,
  output logic                  dmaRspValid
);
  logic isLoad, idxOk, slotBusy;
  logic [ERR_W-1:0] setBits, clrBits, keepBits;

  assign upReady  = !rst;
  assign dmaReady = !rst;

  always_comb begin
    isLoad   = cfgValid && (cfgOp == OP_LOAD);
    idxOk    = cfgSpaceIdx < IDX_W'(NUM_SPACES);
    slotBusy = idxOk && occupied[cfgSpaceIdx[SPACE_W-1:0]];
    setBits  = '0;
    setBits[ERR_BADSPACE] = isLoad && !idxOk;
    setBits[ERR_DUP]      = isLoad && slotBusy;
    setBits[ERR_NOWIN]    = cfgValid && (cfgOp == OP_CHECK) && (occupied == '0);
    clrBits  = clrValid ? clrMask : '0;
    keepBits = errStatus & ~clrBits;
    strb.loadWin   = isLoad && idxOk && !slotBusy;
    strb.initAll   = cfgValid && (cfgOp == OP_INIT);
    strb.upAccept  = upValid && upReady;
    strb.dmaAccept = dmaValid && dmaReady;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errStatus   <= '0;
      upRspValid  <= 1'b0;
      dmaRspValid <= 1'b0;
    end else begin
      errStatus   <= keepBits | setBits;
      upRspValid  <= strb.upAccept;
      dmaRspValid <= strb.dmaAccept;
    end
  end

  // R13: one response in the cycle after each acceptance
  p_rsp_follows_r13: assert property (@(posedge clk) disable iff (rst)
    upRspValid == $past(upValid && upReady));
  p_dma_rsp_follows_r13: assert property (@(posedge clk) disable iff (rst)
    dmaRspValid == $past(dmaValid && dmaReady));
  // R12: bits not cleared stay set
  p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((errStatus & $past(keepBits)) == $past(keepBits)));
  // R4: out-of-range index never loads and flags the fault
  p_bad_idx_r4: assert property (@(posedge clk) disable iff (rst)
    (cfgValid && cfgOp == OP_LOAD && cfgSpaceIdx >= IDX_W'(NUM_SPACES))
      |=> errStatus[ERR_BADSPACE]);
endmodule

// File: rtl/bwx_dpath.sv
module bwx_dpath
  import bwx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               strb,
  input  logic [SPACE_W-1:0]    cfgIdx,
  input  logic [ADDR_W-1:0]     cfgParentBase,
  input  logic [ADDR_W-1:0]     cfgChildBase,
  input  logic [ADDR_W-1:0]     cfgSize,
  input  logic [SPACE_W-1:0]    cfgParentSpace,
  output logic [NUM_SPACES-1:0] occupied,
  input  logic                  upWrite,
  input  logic [ADDR_W-1:0]     upAddr,
  input  logic [LEN_W-1:0]      upLen,
  output logic [LEN_W-1:0]      upRspLen,
  output logic                  upRspErr,
  output logic                  dnValid,
  output logic [SPACE_W-1:0]    dnSpace,
  output logic [ADDR_W-1:0]     dnAddr,
  output logic [LEN_W-1:0]      dnLen,
  output logic                  dnWrite,
  input  logic                  dmaWrite,
  input  logic [SPACE_W-1:0]    dmaSpace,
  input  logic [ADDR_W-1:0]     dmaAddr,
  input  logic [LEN_W-1:0]      dmaLen,
  output logic [LEN_W-1:0]      dmaRspLen,
  output logic                  dmaRspErr,
  output logic                  fwdValid,
  output logic [SPACE_W-1:0]    fwdSpace,
  output logic [ADDR_W-1:0]     fwdAddr,
  output logic [LEN_W-1:0]      fwdLen,
  output logic                  fwdWrite
);
  localparam int EXT_W = ADDR_W + 1;
  localparam int MEM_IDX = 0;

  logic [ADDR_W-1:0]  pBase  [NUM_SPACES];
  logic [ADDR_W-1:0]  cBase  [NUM_SPACES];
  logic [ADDR_W-1:0]  wSize  [NUM_SPACES];
  logic [SPACE_W-1:0] pSpace [NUM_SPACES];

  logic [NUM_SPACES-1:0] hit;
  logic [EXT_W-1:0]      upEnd;
  logic [SPACE_W-1:0]    sel;
  logic                  anyHit;
  logic [ADDR_W-1:0]     xlat;

  logic [EXT_W-1:0] dmaStart, dmaEnd, childLo, childHi;
  logic startIn, endIn, clash, dmaBad;

  // window storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SPACES; i++) begin
        pBase[i]  <= '0;
        cBase[i]  <= '0;
        wSize[i]  <= '0;
        pSpace[i] <= '0;
      end
    end else if (strb.initAll) begin
      for (int i = 0; i < NUM_SPACES; i++) wSize[i] <= '0;
    end else if (strb.loadWin) begin
      pBase[cfgIdx]  <= cfgParentBase;
      cBase[cfgIdx]  <= cfgChildBase;
      wSize[cfgIdx]  <= cfgSize;
      pSpace[cfgIdx] <= cfgParentSpace;
    end
  end

  // per-window full-fit match
  assign upEnd = {1'b0, upAddr} + EXT_W'(upLen);
  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_win
    logic [EXT_W-1:0] winEnd;
    assign winEnd      = {1'b0, pBase[g]} + {1'b0, wSize[g]};
    assign occupied[g] = (wSize[g] != '0);
    assign hit[g]      = occupied[g] && (upAddr >= pBase[g]) && (upEnd <= winEnd);
  end

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int i = NUM_SPACES - 1; i >= 0; i--)
      if (hit[i]) sel = SPACE_W'(i);
  end
  assign anyHit = |hit;
  assign xlat   = upAddr - pBase[sel] + cBase[sel];

  // DMA filter against own downstream memory window
  always_comb begin
    dmaStart = {1'b0, dmaAddr};
    dmaEnd   = dmaStart + EXT_W'(dmaLen);
    childLo  = {1'b0, cBase[MEM_IDX]};
    childHi  = childLo + {1'b0, wSize[MEM_IDX]};
    startIn  = (dmaStart >= childLo) && (dmaStart <= childHi);
    endIn    = (dmaEnd >= childLo) && (dmaEnd <= childHi);
    clash    = occupied[MEM_IDX] && (startIn || endIn);
    dmaBad   = (dmaSpace != SP_MEM) || clash;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upRspLen <= '0; upRspErr <= 1'b0;
      dnValid  <= 1'b0; dnSpace <= '0; dnAddr <= '0; dnLen <= '0; dnWrite <= 1'b0;
      dmaRspLen <= '0; dmaRspErr <= 1'b0;
      fwdValid <= 1'b0; fwdSpace <= '0; fwdAddr <= '0; fwdLen <= '0; fwdWrite <= 1'b0;
    end else begin
      dnValid  <= 1'b0;
      fwdValid <= 1'b0;
      if (strb.upAccept) begin
        dnValid  <= anyHit;
        dnSpace  <= sel;
        dnAddr   <= xlat;
        dnLen    <= upLen;
        dnWrite  <= upWrite;
        upRspLen <= anyHit ? upLen : '0;
        upRspErr <= !anyHit;
      end
      if (strb.dmaAccept) begin
        fwdValid  <= !dmaBad;
        fwdSpace  <= pSpace[MEM_IDX];
        fwdAddr   <= dmaAddr;
        fwdLen    <= dmaLen;
        fwdWrite  <= dmaWrite;
        dmaRspLen <= dmaBad ? '0 : dmaLen;
        dmaRspErr <= dmaBad;
      end
    end
  end

  // R3: a load strobe only ever reaches an unused window
  p_load_free_r3: assert property (@(posedge clk) disable iff (rst)
    strb.loadWin |-> (wSize[cfgIdx] == '0));
  // R11: init leaves every window unused
  p_init_clear_r11: assert property (@(posedge clk) disable iff (rst)
    strb.initAll |=> (occupied == '0));
  // R8: non-memory DMA is refused and not forwarded
  p_dma_space_r8: assert property (@(posedge clk) disable iff (rst)
    (strb.dmaAccept && dmaSpace != SP_MEM) |=> (dmaRspErr && !fwdValid));
  // R6: a refused upstream access never forwards
  p_miss_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.upAccept && hit == '0) |=> (!dnValid && upRspLen == '0));
endmodule

// File: rtl/bridge_window_xlate.sv
module bridge_window_xlate
  import bwx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgValid,
  input  logic [1:0]         cfgOp,
  input  logic [2:0]         cfgSpaceIdx,
  input  logic [ADDR_W-1:0]  cfgParentBase,
  input  logic [ADDR_W-1:0]  cfgChildBase,
  input  logic [ADDR_W-1:0]  cfgSize,
  input  logic [1:0]         cfgParentSpace,
  input  logic               clrValid,
  input  logic [2:0]         clrMask,
  output logic [2:0]         errStatus,
  input  logic               upValid,
  output logic               upReady,
  input  logic               upWrite,
  input  logic [ADDR_W-1:0]  upAddr,
  input  logic [LEN_W-1:0]   upLen,
  output logic               upRspValid,
  output logic [LEN_W-1:0]   upRspLen,
  output logic               upRspErr,
  output logic               dnValid,
  output logic [1:0]         dnSpace,
  output logic [ADDR_W-1:0]  dnAddr,
  output logic [LEN_W-1:0]   dnLen,
  output logic               dnWrite,
  input  logic               dmaValid,
  output logic               dmaReady,
  input  logic               dmaWrite,
  input  logic [1:0]         dmaSpace,
  input  logic [ADDR_W-1:0]  dmaAddr,
  input  logic [LEN_W-1:0]   dmaLen,
  output logic               dmaRspValid,
  output logic [LEN_W-1:0]   dmaRspLen,
  output logic               dmaRspErr,
  output logic               fwdValid,
  output logic [1:0]         fwdSpace,
  output logic [ADDR_W-1:0]  fwdAddr,
  output logic [LEN_W-1:0]   fwdLen,
  output logic               fwdWrite
);
  strobe_t               strb;
  logic [NUM_SPACES-1:0] occupied;

  bwx_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .cfgValid(cfgValid), .cfgOp(cfgOp), .cfgSpaceIdx(cfgSpaceIdx),
    .occupied(occupied), .clrValid(clrValid), .clrMask(clrMask),
    .upValid(upValid), .dmaValid(dmaValid),
    .strb(strb), .errStatus(errStatus),
    .upReady(upReady), .dmaReady(dmaReady),
    .upRspValid(upRspValid), .dmaRspValid(dmaRspValid)
  );

  bwx_dpath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb),
    .cfgIdx(cfgSpaceIdx[SPACE_W-1:0]),
    .cfgParentBase(cfgParentBase), .cfgChildBase(cfgChildBase),
    .cfgSize(cfgSize), .cfgParentSpace(cfgParentSpace),
    .occupied(occupied),
    .upWrite(upWrite), .upAddr(upAddr), .upLen(upLen),
    .upRspLen(upRspLen), .upRspErr(upRspErr),
    .dnValid(dnValid), .dnSpace(dnSpace), .dnAddr(dnAddr),
    .dnLen(dnLen), .dnWrite(dnWrite),
    .dmaWrite(dmaWrite), .dmaSpace(dmaSpace), .dmaAddr(dmaAddr), .dmaLen(dmaLen),
    .dmaRspLen(dmaRspLen), .dmaRspErr(dmaRspErr),
    .fwdValid(fwdValid), .fwdSpace(fwdSpace), .fwdAddr(fwdAddr),
    .fwdLen(fwdLen), .fwdWrite(fwdWrite)
  );
endmodule

// File: tb/test_bridge_window_xlate.sv
module test_bridge_window_xlate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic cfgValid = 0; logic [1:0] cfgOp = 0; logic [2:0] cfgSpaceIdx = 0;
  logic [31:0] cfgParentBase = 0, cfgChildBase = 0, cfgSize = 0;
  logic [1:0] cfgParentSpace = 0;
  logic clrValid = 0; logic [2:0] clrMask = 0;
  logic [2:0] errStatus;
  logic upValid = 0, upWrite = 0; logic [31:0] upAddr = 0; logic [15:0] upLen = 0;
  logic upReady, upRspValid, upRspErr, dnValid, dnWrite;
  logic [15:0] upRspLen, dnLen; logic [1:0] dnSpace; logic [31:0] dnAddr;
  logic dmaValid = 0, dmaWrite = 0; logic [1:0] dmaSpace = 0;
  logic [31:0] dmaAddr = 0; logic [15:0] dmaLen = 0;
  logic dmaReady, dmaRspValid, dmaRspErr, fwdValid, fwdWrite;
  logic [15:0] dmaRspLen, fwdLen; logic [1:0] fwdSpace; logic [31:0] fwdAddr;

  bridge_window_xlate i_bridge_window_xlate (.*);

  // reference model state
  longint mPB[4], mCB[4], mSz[4];
  int     mPS[4];
  logic [2:0] mErr;
  int nChecks = 0, nFail = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    cfgValid = 0; clrValid = 0; upValid = 0; dmaValid = 0;
  endtask

  task automatic load(int idx, longint pb, longint cb, longint sz, int ps);
    cfgValid = 1; cfgOp = 2'd0; cfgSpaceIdx = 3'(idx);
    cfgParentBase = 32'(pb); cfgChildBase = 32'(cb); cfgSize = 32'(sz);
    cfgParentSpace = 2'(ps);
  endtask

  task automatic cmd(int op);
    cfgValid = 1; cfgOp = 2'(op);
  endtask

  task automatic up(longint a, int len, bit wr);
    upValid = 1; upAddr = 32'(a); upLen = 16'(len); upWrite = wr;
  endtask

  task automatic dma(int sp, longint a, int len, bit wr);
    dmaValid = 1; dmaSpace = 2'(sp); dmaAddr = 32'(a); dmaLen = 16'(len); dmaWrite = wr;
  endtask

  // one clock: predict from pre-edge state, compare after the edge
  task automatic step(string tag);
    bit eUp, eDma, dmaBad; int hitIdx; longint a, e, da, de, lo, hi;
    logic [2:0] setB, clrB;
    @(posedge clk);
    eUp = upValid; eDma = dmaValid;
    a = longint'(upAddr); e = a + longint'(upLen);
    hitIdx = -1;
    for (int i = 0; i < 4; i++)
      if (hitIdx < 0 && mSz[i] != 0 && a >= mPB[i] && e <= mPB[i] + mSz[i]) hitIdx = i;
    da = longint'(dmaAddr); de = da + longint'(dmaLen);
    lo = mCB[0]; hi = mCB[0] + mSz[0];
    dmaBad = (dmaSpace != 0) ||
             (mSz[0] != 0 && ((da >= lo && da <= hi) || (de >= lo && de <= hi)));
    setB = 0;
    if (cfgValid) begin
      if (cfgOp == 0) begin
        if (cfgSpaceIdx > 3) setB[0] = 1;
        else if (mSz[cfgSpaceIdx] != 0) setB[1] = 1;
        else begin
          mPB[cfgSpaceIdx] = cfgParentBase; mCB[cfgSpaceIdx] = cfgChildBase;
          mSz[cfgSpaceIdx] = cfgSize; mPS[cfgSpaceIdx] = cfgParentSpace;
        end
      end else if (cfgOp == 1) begin
        for (int i = 0; i < 4; i++) mSz[i] = 0;
      end else if (cfgOp == 2) begin
        if (mSz[0] == 0 && mSz[1] == 0 && mSz[2] == 0 && mSz[3] == 0) setB[2] = 1;
      end
    end
    clrB = clrValid ? clrMask : 3'b0;
    mErr = (mErr & ~clrB) | setB;
    @(negedge clk);
    chk(tag, "upReady", upReady, 1);
    chk(tag, "dmaReady", dmaReady, 1);
    chk(tag, "upRspValid", upRspValid, eUp);
    chk(tag, "dnValid", dnValid, eUp && hitIdx >= 0);
    if (eUp) begin
      chk(tag, "upRspLen", upRspLen, hitIdx >= 0 ? longint'(upLen) : 0);
      chk(tag, "upRspErr", upRspErr, hitIdx < 0);
      if (hitIdx >= 0) begin
        chk(tag, "dnSpace", dnSpace, hitIdx);
        chk(tag, "dnAddr", dnAddr, (a - mPB[hitIdx] + mCB[hitIdx]) & 64'hFFFF_FFFF);
        chk(tag, "dnLen", dnLen, upLen);
        chk(tag, "dnWrite", dnWrite, upWrite);
      end
    end
    chk(tag, "dmaRspValid", dmaRspValid, eDma);
    chk(tag, "fwdValid", fwdValid, eDma && !dmaBad);
    if (eDma) begin
      chk(tag, "dmaRspErr", dmaRspErr, dmaBad);
      chk(tag, "dmaRspLen", dmaRspLen, dmaBad ? 0 : longint'(dmaLen));
      if (!dmaBad) begin
        chk(tag, "fwdSpace", fwdSpace, mPS[0]);
        chk(tag, "fwdAddr", fwdAddr, da);
        chk(tag, "fwdLen", fwdLen, dmaLen);
        chk(tag, "fwdWrite", fwdWrite, dmaWrite);
      end
    end
    chk(tag, "errStatus", errStatus, mErr);
    idle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R13 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mPB[i] = 0; mCB[i] = 0; mSz[i] = 0; mPS[i] = 0; end
    mErr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state, unused windows refuse an access
    step("R1");
    up(32'h8000_0000, 4, 0); step("R1");
    // R11: check with no window
    cmd(2); step("R11");
    // R12: clear it
    clrValid = 1; clrMask = 3'b100; step("R12");
    // R2: load all four spaces
    load(0, 32'h8000_0000, 32'h8000_0000, 32'h1000_0000, 1); step("R2");
    load(1, 32'hC000_0000, 0, 32'h0001_0000, 0); step("R2");
    load(2, 32'hD000_0000, 32'h100, 32'h100, 0); step("R2");
    load(3, 32'h8000_0800, 32'h5000, 32'h1000, 0); step("R2");
    cmd(2); step("R11");
    // R3: duplicate is flagged and ignored
    load(0, 32'h1000_0000, 32'h2222_0000, 32'h100, 2); step("R3");
    up(32'h8000_0010, 8, 1); step("R3");
    // R4: bad index
    load(5, 32'h0, 32'h0, 32'h100, 0); step("R4");
    load(7, 32'h0, 32'h0, 32'h100, 0); step("R4");
    up(32'h0000_0010, 4, 0); step("R4");
    // R5: matches and rebasing
    up(32'h8123_4560, 16, 0); step("R5");
    up(32'hC000_0100, 2, 1); step("R5");
    up(32'hC000_FFFC, 4, 0); step("R5");
    up(32'hD000_0010, 4, 0); step("R5");
    // R6: crossing end, below base, outside all
    up(32'hC000_FFFE, 4, 0); step("R6");
    up(32'h7FFF_FFFF, 1, 0); step("R6");
    up(32'hFFFF_FFF0, 16'hFFFF, 0); step("R6");
    // R7: special overlaps memory, memory wins
    up(32'h8000_0900, 4, 0); step("R7");
    // R8: DMA to non-memory space
    dma(1, 32'h1000, 4, 0); step("R8");
    dma(3, 32'h1000, 4, 1); step("R8");
    // R9: DMA touching own memory window
    dma(0, 32'h8000_0000, 4, 0); step("R9");
    dma(0, 32'h7FFF_FFF0, 16, 0); step("R9");
    dma(0, 32'h9000_0000, 4, 1); step("R9");
    // R10: DMA just outside
    dma(0, 32'h7FFF_FFF0, 15, 1); step("R10");
    dma(0, 32'h9000_0001, 8, 0); step("R10");
    // R12: clear colliding with a fresh fault keeps the bit
    load(6, 0, 0, 1, 0); clrValid = 1; clrMask = 3'b001; step("R12");
    clrValid = 1; clrMask = 3'b011; step("R12");
    // R13: back-to-back on both ports
    for (int k = 0; k < 6; k++) begin
      up(32'hC000_0000 + 32'(k * 4), 4, k[0]);
      dma(0, 32'h1000 + 32'(k * 16), 16, k[1]);
      step("R13");
    end
    // R11: init clears, then memory misses and check flags
    cmd(1); step("R11");
    up(32'h8000_0010, 4, 0); step("R11");
    cmd(2); step("R11");
    dma(0, 32'h8000_0000, 4, 0); step("R10");
    load(0, 32'h4000_0000, 32'h0, 32'h100, 2); step("R2");
    up(32'h4000_00FC, 4, 1); step("R2");
    clrValid = 1; clrMask = 3'b111; step("R12");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule